// File: doc/BRIEF.md
# LDPC Message-Passing Node Processor

This block runs one half-iteration of belief-propagation decoding for a low-density parity-check code at a time. It works through the nodes of the current side of the bipartite graph one after another. In the bit phase it visits every bit node, and in the check phase every check node. Every edge of the graph owns one message word in each of two memory banks. A phase reads all edge messages from one bank and writes the new messages into the other bank. At the end of the phase the two banks trade roles, so the messages written by one phase become the inputs of the next.

A bit node sends back, on each of its edges, its channel log-likelihood ratio plus the sum of the messages on its other edges. A check node sends back, on each of its edges, a min-sum result built from its other edges only. The edge that receives a message never contributes to it. Degrees are fixed by parameters. Bit-node edges occupy consecutive memory slots. A connection table, loaded before decoding, gives the memory slot for each edge of each check node. Every message written is also shown on an output stream, so the caller can follow the decode as it runs.

Top module: `ldpc_node_proc`

## Requirements
- R1: After reset the block is idle: busy, done and msg_valid are 0, phase is 0 (bit phase) and bank_rd is 0.
- R2: In the bit phase, the message for edge k of bit node b is sat(llr[b] + the sum of the messages read on that node's other edges). Here sat() clamps to the range -31..+31, and messages are 6-bit two's complement.
- R3: In the check phase, the message for an edge takes its magnitude from the smallest magnitude among the node's other edges, with an input of -32 counted as magnitude 31. It is negative exactly when an odd number of those other inputs have their sign bit (bit 5) set.
- R4: The bit phase emits edges in bit-major order, at address b*DV+k. The check phase emits them in table order, at address table[c*DC+k], for node c and slot k.
- R5: For a start accepted at clock edge 0 in a phase of node degree D, the first message is registered at edge D+2. The messages then follow on consecutive cycles, NB*DV of them in all.
- R6: done is a single-cycle pulse that coincides with the last message of the phase. bank_rd and phase both flip at the edge that raises done and stay unchanged at every other edge.
- R7: Messages are written to the bank that is not selected by bank_rd, and the next phase reads them back as its inputs. A sequence of phases therefore carries out successive half-iterations without any reload.
- R8: start is accepted only while busy is 0. A start pulse during a phase has no effect on the message count or on the timing.
- R9: Configuration writes use cfg_sel: 0 writes cfg_idx into table entry cfg_addr, 1 writes cfg_val as the channel value of bit node cfg_addr, and 2 writes cfg_val into edge cfg_addr of the bank selected by bank_rd.
- R10: An emitted message never equals -32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Configuration target: 0 table, 1 channel value, 2 edge message |
| cfg_addr | input | EW | Table entry, bit node or edge index |
| cfg_idx | input | EW | Edge index stored into the table |
| cfg_val | input | W | Channel value or message word |
| start | input | 1 | Begin one half-iteration |
| busy | output | 1 | A half-iteration is in progress |
| phase | output | 1 | 0 bit phase, 1 check phase |
| bank_rd | output | 1 | Bank read by the next or current phase |
| done | output | 1 | One-cycle pulse at the end of a phase |
| msg_valid | output | 1 | A message was written this cycle |
| msg_addr | output | EW | Edge index of the written message |
| msg_data | output | W | Written message |

## Verification
The outputs of a phase with degree D are due at fixed cycles after the edge that accepts start. The first message appears D+2 edges later, and the remaining messages follow one per cycle. done, the bank flip and the phase flip land together with the last message, D+1+NB*DV edges after the start edge. The bench counts falling edges from the accepting edge and samples each cycle midway between edges. At every sample it compares msg_valid and done against the cycle windows given above. It checks the address and value of each message as it arrives against a model built from sums and minimum searches. Runs of four phases per pattern show that each phase reads back what the previous phase wrote.

// File: rtl/ldpc_np_pkg.sv
package ldpc_np_pkg;
  typedef enum logic {PH_BIT = 1'b0, PH_CHK = 1'b1} phase_e;
  typedef enum logic [1:0] {
    CFG_TBL  = 2'd0,
    CFG_LLR  = 2'd1,
    CFG_MSG  = 2'd2,
    CFG_NONE = 2'd3
  } cfg_e;
endpackage

// File: rtl/ldpc_np_ctrl.sv
// Node/slot sequencer: issues one edge read per cycle for the active phase.
module ldpc_np_ctrl #(
  parameter int DV = 4,
  parameter int DC = 36,
  parameter int NB = 36,
  parameter int NC = 4,
  parameter int NW = 6,
  parameter int SW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          phase,
  input  logic          swap,
  output logic          busy,
  output logic          iss_valid,
  output logic [NW-1:0] iss_node,
  output logic [SW-1:0] iss_slot,
  output logic          iss_first,
  output logic          iss_last,
  output logic          iss_lastnode
);
  logic          issuing;
  logic [NW-1:0] node;
  logic [SW-1:0] slot;
  logic [SW-1:0] deg_m1;
  logic [NW-1:0] nodes_m1;

  assign deg_m1   = phase ? SW'(DC - 1) : SW'(DV - 1);
  assign nodes_m1 = phase ? NW'(NC - 1) : NW'(NB - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      issuing <= 1'b0;
      node    <= '0;
      slot    <= '0;
    end else if (!busy && start) begin
      busy    <= 1'b1;
      issuing <= 1'b1;
      node    <= '0;
      slot    <= '0;
    end else begin
      if (issuing) begin
        if (slot == deg_m1) begin
          slot <= '0;
          if (node == nodes_m1) issuing <= 1'b0;
          else                  node    <= node + 1'b1;
        end else begin
          slot <= slot + 1'b1;
        end
      end
      if (swap) busy <= 1'b0;
    end
  end

  assign iss_valid    = issuing;
  assign iss_node     = node;
  assign iss_slot     = slot;
  assign iss_first    = (slot == '0);
  assign iss_last     = (slot == deg_m1);
  assign iss_lastnode = (node == nodes_m1);
endmodule

// File: rtl/ldpc_np_vnu.sv
// Bit-node unit: accumulates channel value plus all inputs, emits total minus own input.
module ldpc_np_vnu #(
  parameter int W   = 6,
  parameter int DV  = 4,
  parameter int VSW = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  input  logic           in_first,
  input  logic           in_last,
  input  logic [VSW-1:0] in_slot,
  input  logic [W-1:0]   in_data,
  input  logic [W-1:0]   llr,
  input  logic [VSW-1:0] e_slot,
  output logic [W-1:0]   e_data
);
  localparam int TW = W + $clog2(DV + 1) + 1;

  function automatic logic signed [TW-1:0] sx(input logic [W-1:0] x);
    return {{(TW-W){x[W-1]}}, x};
  endfunction

  function automatic logic [W-1:0] sat_msg(input logic signed [TW-1:0] v);
    logic signed [TW-1:0] lim;
    lim = TW'((2 ** (W - 1)) - 1);
    if (v > lim) return lim[W-1:0];
    if (v < -lim) begin
      lim = -lim;
      return lim[W-1:0];
    end
    return v[W-1:0];
  endfunction

  logic signed [TW-1:0] acc, etot, base, nxt;
  logic [W-1:0] gbuf [DV];
  logic [W-1:0] ebuf [DV];

  always_comb begin
    base = in_first ? sx(llr) : acc;
    nxt  = base + sx(in_data);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc  <= '0;
      etot <= '0;
    end else if (in_valid) begin
      acc <= nxt;
      if (in_last) etot <= nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (in_valid) begin
      gbuf[in_slot] <= in_data;
      if (in_last)
        for (int k = 0; k < DV; k++)
          ebuf[k] <= (VSW'(k) == in_slot) ? in_data : gbuf[k];
    end
  end

  assign e_data = sat_msg(etot - sx(ebuf[e_slot]));
endmodule

// File: rtl/ldpc_np_cnu.sv
// Check-node unit: one-pass min1/min2/sign tracking, then per-edge min-sum output.
module ldpc_np_cnu #(
  parameter int W   = 6,
  parameter int DC  = 36,
  parameter int CSW = 6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  input  logic           in_first,
  input  logic           in_last,
  input  logic [CSW-1:0] in_slot,
  input  logic [W-1:0]   in_data,
  input  logic [CSW-1:0] e_slot,
  output logic [W-1:0]   e_data
);
  localparam int MW = W - 1;

  function automatic logic [MW-1:0] mag_of(input logic [W-1:0] x);
    logic [W-1:0] n;
    n = x[W-1] ? (~x + 1'b1) : x;
    return n[W-1] ? '1 : n[MW-1:0];
  endfunction

  logic [MW-1:0]  m1, m2, em1, em2, cm, b1, b2, n1, n2, om;
  logic [CSW-1:0] idx, eidx, bi, ni;
  logic           sxr, esx, bs, ns, os;
  logic [DC-1:0]  gsgn, esgn;
  logic [W-1:0]   v;

  always_comb begin
    cm = mag_of(in_data);
    b1 = in_first ? '1 : m1;
    b2 = in_first ? '1 : m2;
    bi = in_first ? '0 : idx;
    bs = in_first ? 1'b0 : sxr;
    if (cm < b1) begin
      n1 = cm; n2 = b1; ni = in_slot;
    end else if (cm < b2) begin
      n1 = b1; n2 = cm; ni = bi;
    end else begin
      n1 = b1; n2 = b2; ni = bi;
    end
    ns = bs ^ in_data[W-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m1 <= '0; m2 <= '0; idx <= '0; sxr <= 1'b0;
      em1 <= '0; em2 <= '0; eidx <= '0; esx <= 1'b0;
      gsgn <= '0; esgn <= '0;
    end else if (in_valid) begin
      m1 <= n1; m2 <= n2; idx <= ni; sxr <= ns;
      gsgn[in_slot] <= in_data[W-1];
      if (in_last) begin
        em1 <= n1; em2 <= n2; eidx <= ni; esx <= ns;
        for (int k = 0; k < DC; k++)
          esgn[k] <= (CSW'(k) == in_slot) ? in_data[W-1] : gsgn[k];
      end
    end
  end

  always_comb begin
    om     = (e_slot == eidx) ? em2 : em1;
    os     = esx ^ esgn[e_slot];
    v      = {1'b0, om};
    e_data = os ? (~v + 1'b1) : v;
  end
endmodule

// File: rtl/ldpc_node_proc.sv
// Top: double-banked edge memory, connection table, gather/emit pipeline.
module ldpc_node_proc
  import ldpc_np_pkg::*;
#(
  parameter int W  = 6,
  parameter int DV = 4,
  parameter int DC = 36,
  parameter int NB = 36,
  parameter int NC = 4,
  parameter int E  = NB * DV,
  parameter int EW = $clog2(E)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_sel,
  input  logic [EW-1:0] cfg_addr,
  input  logic [EW-1:0] cfg_idx,
  input  logic [W-1:0]  cfg_val,
  input  logic          start,
  output logic          busy,
  output logic          phase,
  output logic          bank_rd,
  output logic          done,
  output logic          msg_valid,
  output logic [EW-1:0] msg_addr,
  output logic [W-1:0]  msg_data
);
  localparam int DMAX = (DV > DC) ? DV : DC;
  localparam int NMAX = (NB > NC) ? NB : NC;
  localparam int SW   = $clog2(DMAX);
  localparam int NW   = $clog2(NMAX);
  localparam int VSW  = $clog2(DV);
  localparam int CSW  = $clog2(DC);

  logic [W-1:0]  mem     [2][E];
  logic [EW-1:0] tbl     [E];
  logic [W-1:0]  llr_mem [NB];
  phase_e        ph;

  // named internal events
  logic          iss_valid, iss_first, iss_last, iss_lastnode;
  logic [NW-1:0] iss_node;
  logic [SW-1:0] iss_slot;
  logic [EW-1:0] iss_addr;
  logic          swap, load, e_last;

  logic          g_valid, g_first, g_last, g_lastnode;
  logic [SW-1:0] g_slot;
  logic [NW-1:0] g_node;
  logic [EW-1:0] g_addr;
  logic [W-1:0]  g_data;

  logic          e_active, e_lastnode;
  logic [SW-1:0] e_cnt, deg_m1;
  logic [EW-1:0] gaddr [DMAX];
  logic [EW-1:0] eaddr [DMAX];
  logic [W-1:0]  v_e, c_e, e_data;

  ldpc_np_ctrl #(.DV(DV), .DC(DC), .NB(NB), .NC(NC), .NW(NW), .SW(SW)) u_ctrl (
    .clk, .rst_n, .start, .phase(ph), .swap, .busy,
    .iss_valid, .iss_node, .iss_slot, .iss_first, .iss_last, .iss_lastnode
  );

  always_comb begin
    if (ph == PH_BIT) iss_addr = EW'(iss_node) * EW'(DV) + EW'(iss_slot);
    else              iss_addr = tbl[EW'(iss_node) * EW'(DC) + EW'(iss_slot)];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      g_valid <= 1'b0; g_first <= 1'b0; g_last <= 1'b0; g_lastnode <= 1'b0;
      g_slot <= '0; g_node <= '0; g_addr <= '0;
    end else begin
      g_valid <= iss_valid; g_first <= iss_first; g_last <= iss_last;
      g_lastnode <= iss_lastnode; g_slot <= iss_slot; g_node <= iss_node;
      g_addr <= iss_addr;
    end
  end

  ldpc_np_vnu #(.W(W), .DV(DV), .VSW(VSW)) u_vnu (
    .clk, .rst_n,
    .in_valid(g_valid && ph == PH_BIT), .in_first(g_first), .in_last(g_last),
    .in_slot(g_slot[VSW-1:0]), .in_data(g_data), .llr(llr_mem[g_node]),
    .e_slot(e_cnt[VSW-1:0]), .e_data(v_e)
  );

  ldpc_np_cnu #(.W(W), .DC(DC), .CSW(CSW)) u_cnu (
    .clk, .rst_n,
    .in_valid(g_valid && ph == PH_CHK), .in_first(g_first), .in_last(g_last),
    .in_slot(g_slot[CSW-1:0]), .in_data(g_data),
    .e_slot(e_cnt[CSW-1:0]), .e_data(c_e)
  );

  assign e_data = (ph == PH_BIT) ? v_e : c_e;
  assign deg_m1 = (ph == PH_BIT) ? SW'(DV - 1) : SW'(DC - 1);
  assign load   = g_valid && g_last;
  assign e_last = e_active && (e_cnt == deg_m1);
  assign swap   = e_last && e_lastnode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e_active <= 1'b0; e_cnt <= '0; e_lastnode <= 1'b0;
      msg_valid <= 1'b0; done <= 1'b0; bank_rd <= 1'b0; ph <= PH_BIT;
      msg_addr <= '0; msg_data <= '0;
    end else begin
      if (load) begin
        e_active <= 1'b1; e_cnt <= '0; e_lastnode <= g_lastnode;
      end else if (e_active) begin
        e_cnt <= e_cnt + 1'b1;
        if (e_last) e_active <= 1'b0;
      end
      msg_valid <= e_active;
      msg_addr  <= eaddr[e_cnt];
      msg_data  <= e_data;
      done      <= swap;
      if (swap) begin
        bank_rd <= ~bank_rd;
        ph      <= (ph == PH_BIT) ? PH_CHK : PH_BIT;
      end
    end
  end

  always_ff @(posedge clk) begin
    g_data <= mem[bank_rd][iss_addr];
    if (g_valid) begin
      gaddr[g_slot] <= g_addr;
      if (g_last)
        for (int k = 0; k < DMAX; k++)
          eaddr[k] <= (SW'(k) == g_slot) ? g_addr : gaddr[k];
    end
    if (e_active) mem[~bank_rd][eaddr[e_cnt]] <= e_data;
    if (cfg_we && cfg_sel == CFG_MSG) mem[bank_rd][cfg_addr] <= cfg_val;
    if (cfg_we && cfg_sel == CFG_TBL) tbl[cfg_addr] <= cfg_idx;
    if (cfg_we && cfg_sel == CFG_LLR) llr_mem[cfg_addr] <= cfg_val;
  end

  assign phase = ph;
endmodule

// File: rtl/ldpc_node_proc_chk.sv
module ldpc_node_proc_chk #(
  parameter int W = 6
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         busy,
  input logic         done,
  input logic         bank_rd,
  input logic         phase,
  input logic         msg_valid,
  input logic [W-1:0] msg_data,
  input logic         iss_valid,
  input logic         swap
);
  a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r6_bank_flip: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> bank_rd != $past(bank_rd));
  a_r6_bank_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(bank_rd));
  a_r6_phase_flip: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> phase != $past(phase));
  a_r6_phase_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(phase));
  a_r10_no_min: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> msg_data != {1'b1, {(W-1){1'b0}}});
  a_r5_issue_in_run: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid |-> busy);
  a_r5_msg_in_run: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> (busy || done));
  a_r8_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !swap) |=> busy);
endmodule

bind ldpc_node_proc ldpc_node_proc_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .bank_rd(bank_rd), .phase(phase), .msg_valid(msg_valid), .msg_data(msg_data),
  .iss_valid(iss_valid), .swap(swap)
);

// File: tb/ldpc_node_proc_tb.sv
module ldpc_node_proc_tb;
  localparam int W = 6, DV = 2, DC = 4, NB = 4, NC = 2, E = NB * DV, EW = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0, start = 1'b0;
  logic [1:0] cfg_sel = '0;
  logic [EW-1:0] cfg_addr = '0, cfg_idx = '0;
  logic [W-1:0] cfg_val = '0;
  logic busy, phase, bank_rd, done, msg_valid;
  logic [EW-1:0] msg_addr;
  logic [W-1:0] msg_data;

  ldpc_node_proc #(.W(W), .DV(DV), .DC(DC), .NB(NB), .NC(NC)) u_dut (
    .clk, .rst_n, .cfg_we, .cfg_sel, .cfg_addr, .cfg_idx, .cfg_val, .start,
    .busy, .phase, .bank_rd, .done, .msg_valid, .msg_addr, .msg_data
  );

  always #2 clk = ~clk;

  int n_chk = 0, n_fail = 0, seed = 7;
  int m [E];
  int llr [NB];
  int tbl [E];
  int expv [E];
  int ord [E];
  int bph = 0, bbank = 0;

  task automatic chk(bit ok, string rq, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  function automatic int rnd();
    seed = seed * 1103515245 + 12345;
    return ((seed >>> 16) & 63) - 32;
  endfunction

  function automatic int clampv(int v);
    return (v > 31) ? 31 : (v < -31) ? -31 : v;
  endfunction

  function automatic int magv(int v);
    return (v == -32) ? 31 : (v < 0 ? -v : v);
  endfunction

  task automatic cfg(int sel, int addr, int idx, int val);
    cfg_we = 1'b1; cfg_sel = sel[1:0]; cfg_addr = addr[EW-1:0];
    cfg_idx = idx[EW-1:0]; cfg_val = val[W-1:0];
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // R9: sel 0 table, 1 channel value, 2 message into read bank
  task automatic load_round(int kind, int mul, int off);
    for (int i = 0; i < E; i++) begin
      tbl[i] = (i * mul + off) % E;
      cfg(0, i, tbl[i], 0);
    end
    for (int b = 0; b < NB; b++) begin
      llr[b] = (kind == 2) ? 31 : (kind == 3) ? -32 : rnd();
      cfg(1, b, 0, llr[b]);
    end
    for (int i = 0; i < E; i++) begin
      m[i] = (kind == 0) ? 0 : (kind == 2) ? 31 : (kind == 3) ? -32 :
             (kind == 4) ? ((i % 3 == 0) ? -5 : 5) : rnd();
      cfg(2, i, 0, m[i]);
    end
  endtask

  task automatic run_half(int half);
    int d, cyc, n, s, mn, sg, e, old_bank, old_ph;
    string rq;
    d = bph ? DC : DV;
    if (bph == 0) begin
      for (int b = 0; b < NB; b++)
        for (int k = 0; k < DV; k++) begin
          s = llr[b];
          for (int j = 0; j < DV; j++) if (j != k) s += m[b*DV + j];
          ord[b*DV + k] = b*DV + k;
          expv[b*DV + k] = clampv(s);
        end
      rq = "R2";
    end else begin
      for (int c = 0; c < NC; c++)
        for (int k = 0; k < DC; k++) begin
          mn = 99; sg = 0;
          for (int j = 0; j < DC; j++) if (j != k) begin
            e = tbl[c*DC + j];
            if (magv(m[e]) < mn) mn = magv(m[e]);
            if (m[e] < 0) sg ^= 1;
          end
          ord[c*DC + k] = tbl[c*DC + k];
          expv[tbl[c*DC + k]] = sg ? -mn : mn;
        end
      rq = "R3";
    end
    if (half > 0) rq = {rq, " R7"};
    old_bank = bank_rd; old_ph = phase;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 1; n = 0;
    while (cyc <= d + E + 5) begin
      if (cyc == 3) start = 1'b1;   // R8: ignored while busy
      if (cyc == 4) start = 1'b0;
      chk(msg_valid == (cyc >= d + 3 && cyc <= d + 2 + E), "R5", "msg_valid window",
          msg_valid, cyc);
      chk(done == (cyc == d + 2 + E), "R6", "done timing", done, cyc);
      if (msg_valid && n < E) begin
        chk(msg_addr == ord[n][EW-1:0], "R4", "edge order", msg_addr, ord[n]);
        chk(int'($signed(msg_data)) == expv[ord[n]], rq, "message value",
            int'($signed(msg_data)), expv[ord[n]]);
        n++;
      end
      @(negedge clk);
      cyc++;
    end
    chk(n == E, "R8", "message count", n, E);
    chk(bank_rd != old_bank[0], "R6", "bank flip", bank_rd, !old_bank);
    chk(phase != old_ph[0], "R6", "phase flip", phase, !old_ph);
    chk(busy == 1'b0, "R8", "idle after phase", busy, 0);
    for (int i = 0; i < E; i++) m[i] = expv[i];
    bph ^= 1;
  endtask

  initial begin
    #(4 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 0, "R1", "busy at reset", busy, 0);
    chk(done == 0, "R1", "done at reset", done, 0);
    chk(msg_valid == 0, "R1", "msg_valid at reset", msg_valid, 0);
    chk(phase == 0, "R1", "phase at reset", phase, 0);
    chk(bank_rd == 0, "R1", "bank at reset", bank_rd, 0);
    for (int r = 0; r < 8; r++) begin
      load_round(r % 6, 2 * (r % 4) + 1, r);
      for (int h = 0; h < 4; h++) run_half(h);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule